// File: doc/BRIEF.md
# Multimedia Microsecond Timer

A free-running up-counter that advances once per microsecond, derived from the 24.576 MHz codec clock. Software reads it to measure elapsed time, for example to keep video frames aligned with an audio stream. The tick comes from a fractional divider. It adds `DIV_DEN` to an accumulator on every clock and fires when the sum reaches `DIV_NUM`. With the defaults 3072/125, ticks fall 24 or 25 clocks apart, so the long-term rate is exactly one tick per 24.576 clocks.

The counter is reached through a small byte-wide register port. The count is split into byte lanes. Reading the lowest lane captures the upper lanes into a shadow register, so a multi-byte read sees one consistent value. Writing a lane preloads those counter bits. A control register holds three bits: a divider bypass that steps the counter on every clock (for test), a software hold that keeps the counter at zero, and an interrupt enable. A sticky status bit records each wrap of the counter to zero, so software may either poll that bit or take the interrupt.

Register addresses: 1 = count bits 7:0, 2 = count bits 15:8 (shadow), 3 = count bits 19:16 in data bits 3:0 (shadow), 4 = control, 5 = status. Any other address reads zero.

Top module: `mm_usec_timer`

## Requirements
- R1: After reset the count, control register, status register and shadow are zero, and irq_o is low.
- R2: Without bypass, the accumulator gains DIV_DEN each clock. A tick occurs in a clock where the current value plus DIV_DEN reaches DIV_NUM, and that value minus DIV_NUM is then kept. The count rises by one per tick and is otherwise unchanged. The maximum gap between ticks is ceil(DIV_NUM/DIV_DEN) clocks.
- R3: With control bit 2 (fast) set, the count rises by one on every clock.
- R4: With control bit 1 (hold) set, the count is forced to zero on every clock, and writes to the count lanes have no effect.
- R5: Control bits 3:1 take the written data bits 3:1. A read of the control register returns zero in bit 0 and in bits 7:4.
- R6: Address 1 reads count bits 7:0 live. A read strobe there captures count bits 19:8 into the shadow on that clock. Addresses 2 and 3 return shadow bits 7:0 and shadow bits 11:8, the latter in data bits 3:0 with zeros above.
- R7: A write to address 1, 2 or 3 loads count bits 7:0, 15:8 or 19:16 (from data bits 3:0). The load replaces that lane's incremented value, and the other lanes still advance.
- R8: A step from the all-ones count, when not held and not loaded, wraps the count to zero and sets status bit 0. The bit stays set until data bit 0 = 1 is written to address 5, and writing 0 has no effect. When a wrap and a clear fall in the same clock, the bit stays set.
- R9: irq_o is high exactly when status bit 0 and control bit 3 (interrupt enable) are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Codec clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (captures shadow at address 1) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Wrap interrupt, level |

## Verification
The bench builds the timer with DIV_NUM = 5 and DIV_DEN = 2, which keeps the 20-bit count. Ticks then alternate between 2- and 3-clock gaps, so the remainder handling of the fractional divider is exercised dozens of times in a short run. Keeping the full count width forces the wrap tests to depend on lane preloads that bring the count next to all-ones. Those preloads also place a wrap in the same clock as a status clear, and they show the shadow holding a stale upper value while the live low byte moves on.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int ADDR_W    = 3;
  localparam int ADDR_CNT0 = 1;
  localparam int CTL_HOLD  = 1;
  localparam int CTL_FAST  = 2;
  localparam int CTL_IEN   = 3;
endpackage

// File: rtl/mmt_tick_div.sv
module mmt_tick_div #(
  parameter int DIV_NUM = 3072,
  parameter int DIV_DEN = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int AW = $clog2(DIV_NUM + DIV_DEN);

  logic [AW-1:0] acc_q, sum;

  assign sum    = acc_q + AW'(DIV_DEN);
  assign tick_o = (sum >= AW'(DIV_NUM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_o) acc_q <= sum - AW'(DIV_NUM);
    else             acc_q <= sum;
  end
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int CNT_W = 20,
  parameter int NLANE = (CNT_W + 7) / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             hold_i,
  input  logic [NLANE-1:0] ld_en_i,
  input  logic [7:0]       ld_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, inc, ld_mask, ld_val, nxt;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LO = 8 * k;
    localparam int HI = (8 * k + 8 > CNT_W) ? CNT_W - 1 : 8 * k + 7;
    assign ld_mask[HI:LO] = {(HI - LO + 1){ld_en_i[k]}};
    assign ld_val[HI:LO]  = ld_data_i[HI-LO:0];
  end

  assign inc = step_i ? cnt_q + CNT_W'(1) : cnt_q;
  assign nxt = (inc & ~ld_mask) | (ld_val & ld_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else             cnt_q <= nxt;
  end

  assign wrap_o = step_i & ~hold_i & ~(|ld_en_i) & (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/mm_usec_timer.sv
module mm_usec_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int DIV_NUM = 3072,
  parameter int DIV_DEN = 125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int NLANE     = (CNT_W + 7) / 8;
  localparam int ADDR_CTL  = ADDR_CNT0 + NLANE;
  localparam int ADDR_STAT = ADDR_CTL + 1;

  logic             tick, step, wrap, ld_any, clr_req;
  logic [CNT_W-1:0] cnt;
  logic [NLANE-1:0] ld_en;
  logic [3:1]       ctrl_q;
  logic             stat_q;
  logic [CNT_W-9:0] shadow_q;
  logic [NLANE*8-1:0] rd_vec;

  mmt_tick_div #(.DIV_NUM(DIV_NUM), .DIV_DEN(DIV_DEN)) i_div (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_ld
    assign ld_en[k] = wr_i && (addr_i == ADDR_W'(ADDR_CNT0 + k));
  end
  assign ld_any  = |ld_en;
  assign step    = ctrl_q[CTL_FAST] | tick;
  assign clr_req = wr_i && (addr_i == ADDR_W'(ADDR_STAT)) && wdata_i[0];

  mmt_counter #(.CNT_W(CNT_W), .NLANE(NLANE)) i_cnt (
    .clk_i, .rst_ni,
    .step_i(step), .hold_i(ctrl_q[CTL_HOLD]),
    .ld_en_i(ld_en), .ld_data_i(wdata_i),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      stat_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_W'(ADDR_CTL)) ctrl_q <= wdata_i[3:1];
      if (wrap)         stat_q <= 1'b1;   // set wins over clear
      else if (clr_req) stat_q <= 1'b0;
      if (rd_i && addr_i == ADDR_W'(ADDR_CNT0)) shadow_q <= cnt[CNT_W-1:8];
    end
  end

  always_comb begin
    rd_vec = '0;
    rd_vec[CNT_W-1:0] = {shadow_q, cnt[7:0]};
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTL))       rdata_o = {4'b0, ctrl_q, 1'b0};
    else if (addr_i == ADDR_W'(ADDR_STAT)) rdata_o = {7'b0, stat_q};
    else begin
      for (int k = 0; k < NLANE; k++)
        if (addr_i == ADDR_W'(ADDR_CNT0 + k)) rdata_o = rd_vec[8*k +: 8];
    end
  end

  assign irq_o = stat_q & ctrl_q[CTL_IEN];
endmodule

// File: rtl/mmt_chk.sv
module mmt_chk #(
  parameter int CNT_W   = 20,
  parameter int DIV_NUM = 3072,
  parameter int DIV_DEN = 125
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             step,
  input logic             hold,
  input logic             ld_any,
  input logic [CNT_W-1:0] cnt,
  input logic             stat,
  input logic             clr_req
);
  localparam int MAXGAP = (DIV_NUM + DIV_DEN - 1) / DIV_DEN;
  localparam int GW     = $clog2(MAXGAP + 1);

  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + GW'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |-> gap_q < GW'(MAXGAP - 1));

  // R2
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !hold && !ld_any) |=> cnt == $past(cnt));

  // R3
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !hold && !ld_any && !(&cnt)) |=> cnt == $past(cnt) + CNT_W'(1));

  // R4
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> cnt == '0);

  // R8
  wrap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !hold && !ld_any && (&cnt)) |=> stat && cnt == '0);

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat && !clr_req) |=> stat);
endmodule

bind mm_usec_timer mmt_chk #(.CNT_W(CNT_W), .DIV_NUM(DIV_NUM), .DIV_DEN(DIV_DEN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .step(step),
  .hold(ctrl_q[1]), .ld_any(ld_any), .cnt(cnt), .stat(stat_q), .clr_req(clr_req)
);

// File: tb/test_mm_usec_timer.sv
module test_mm_usec_timer;
  localparam int CW = 20, NM = 5, DN = 2;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 0, rst_ni = 0, wr_i = 0, rd_i = 0, irq_o;
  logic [2:0] addr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;

  always #5 clk = ~clk;

  mm_usec_timer #(.CNT_W(CW), .DIV_NUM(NM), .DIV_DEN(DN)) i_mm_usec_timer (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  int total = 0, bad = 0;
  int m_acc = 0, m_cnt = 0, m_sh = 0, m_ctrl = 0, m_stat = 0;
  string tag = "R1";

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      1: return m_cnt & 'hFF;
      2: return m_sh & 'hFF;
      3: return (m_sh >> 8) & 'hF;
      4: return m_ctrl;
      5: return m_stat;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(bit wr, bit rd, int a, int wd);
    int sum = m_acc + DN;
    bit tk = (sum >= NM);
    bit stp = tk || m_ctrl[2];
    bit hold = m_ctrl[1];
    bit ld = wr && a >= 1 && a <= 3;
    bit wrp = stp && !hold && !ld && (m_cnt == MASK);
    int n;
    if (rd && a == 1) m_sh = m_cnt >> 8;
    if (hold) m_cnt = 0;
    else begin
      n = stp ? ((m_cnt + 1) & MASK) : m_cnt;
      if (wr && a == 1) n = (n & ~'hFF) | (wd & 'hFF);
      if (wr && a == 2) n = (n & ~'hFF00) | ((wd & 'hFF) << 8);
      if (wr && a == 3) n = (n & 'hFFFF) | ((wd & 'hF) << 16);
      m_cnt = n;
    end
    if (wrp) m_stat = 1;
    else if (wr && a == 5 && wd[0]) m_stat = 0;
    if (wr && a == 4) m_ctrl = wd & 'hE;
    m_acc = tk ? sum - NM : sum;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(bit wr, bit rd, int a, int wd);
    wr_i = wr; rd_i = rd; addr_i = a[2:0]; wdata_i = wd[7:0];
    #1;
    chk(tag, int'(rdata_o), exp_rd(a));
    chk("R9", int'(irq_o), m_stat & ((m_ctrl >> 3) & 1));
    @(posedge clk);
    model_step(wr, rd, a, wd);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tag = "R1";
    #1;
    chk("R1", int'(rdata_o), 0);
    chk("R1", int'(irq_o), 0);
    cyc(0, 0, 4, 0);
    cyc(0, 0, 5, 0);
    cyc(0, 0, 2, 0);
    cyc(0, 0, 3, 0);
    for (int a = 0; a < 8; a++) if (a == 0 || a > 5) cyc(0, 0, a, 0);

    tag = "R2";
    for (int i = 0; i < 40; i++) cyc(0, (i % 4) == 0, 1 + (i % 3), 0);

    tag = "R5";
    cyc(1, 0, 4, 'hFF);
    cyc(0, 0, 4, 0);
    chk("R5", int'(rdata_o), 'h0E);

    tag = "R4";
    cyc(1, 0, 1, 'h55);
    cyc(1, 0, 3, 'h7);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
    cyc(0, 0, 3, 0);

    tag = "R3";
    cyc(1, 0, 4, 'h0C);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0);

    tag = "R7";
    cyc(1, 0, 3, 'hAF);
    cyc(1, 0, 2, 'hFF);
    cyc(1, 0, 1, 'hFF);

    tag = "R8";
    cyc(1, 0, 5, 'h01);   // clear lands on the wrap clock
    cyc(0, 0, 5, 0);
    chk("R8", int'(rdata_o), 1);
    cyc(1, 0, 5, 'h00);
    cyc(0, 0, 5, 0);
    cyc(1, 0, 5, 'h01);
    cyc(0, 0, 5, 0);
    chk("R8", int'(rdata_o), 0);

    tag = "R9";
    cyc(1, 0, 4, 'h04);
    cyc(1, 0, 3, 'h0F);
    cyc(1, 0, 2, 'hFF);
    cyc(1, 0, 1, 'hFE);
    for (int i = 0; i < 4; i++) cyc(0, 0, 5, 0);
    cyc(1, 0, 4, 'h0C);
    cyc(0, 0, 5, 0);
    chk("R9", int'(irq_o), 1);
    cyc(1, 0, 5, 'h01);
    cyc(0, 0, 5, 0);

    tag = "R6";
    cyc(1, 0, 4, 'h00);
    cyc(1, 0, 3, 'h01);
    cyc(1, 0, 2, 'h23);
    cyc(1, 0, 1, 'hF8);
    cyc(0, 1, 1, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0);
    cyc(0, 0, 2, 0);
    chk("R6", int'(rdata_o), 'h23);
    cyc(0, 0, 3, 0);
    chk("R6", int'(rdata_o), 'h1);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 2, 0);
    cyc(0, 0, 3, 0);

    tag = "R2";
    for (int i = 0; i < 30; i++) cyc(0, 1, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule